// File: doc/BRIEF.md
# Envelope-Shaped DDS Pulse Generator

This block produces shaped RF pulses for a DAC. A real-time scheduler sends one control word per pulse over an AXI4-Stream slave port. Each word sets the pulse's own carrier frequency, starting phase, signed gain, envelope base address and length in samples. The carrier frequency can therefore change from one pulse to the next.

A 32-bit phase accumulator drives a small sine/cosine table. The carrier that comes out of the table is multiplied by a complex I/Q envelope read from an on-block memory. The envelope memory is loaded through a separate write port before a pulse uses it. The result is then scaled by the pulse gain and saturated. The block emits one I sample and one Q sample per clock while a pulse plays, and it drives zeros when it is idle.

A two-state machine does the sequencing. **IDLE** waits for a word; the transition *accept* (handshake with a non-zero length) moves it to **PLAY**, and the transition *discard* (handshake with length zero) keeps it in IDLE. **PLAY** emits samples; the transition *finish* (the last sample is issued) returns it to IDLE, and *continue* keeps it in PLAY.

Top module: `pulse_gen`

## Requirements
- R1: The control word `s_tdata` carries the frequency in bits [31:0], the phase offset in [63:32], the signed gain in [79:64], the envelope base address in [95:80] (only the low ENV_AW bits are used) and the length in [111:96]. A word is taken on a rising edge where `s_tvalid` and `s_tready` are both high. `s_tready` is high only in IDLE, so any word offered during PLAY is ignored.
- R2: After a word with length L>0 is accepted on edge E0, `dac_valid` is high after edges E1..EL, with one sample per edge and no gaps. It is low again after edge EL+1.
- R3: Sample n uses phase p = phase_offset + n·freq (mod 2^32). The table index is k = p[31:24] (LUT_BITS=8). sin = T[k] and cos = T[(k+64) mod 256], where T[k] = 32767·sin(2πk/256) rounded half away from zero.
- R4: Sample n reads envelope entry (base + n) mod 2^ENV_AW. A cycle with `env_we` high writes `env_wi` and `env_wq` at `env_waddr`.
- R5: mi = (I·cos − Q·sin) >>> 15 and mq = (I·sin + Q·cos) >>> 15. The outputs are `dac_i` = sat((mi·gain) >>> 15) and `dac_q` = sat((mq·gain) >>> 15), with arithmetic shifts.
- R6: Saturation clamps results to the range −32768..32767.
- R7: When `dac_valid` is low, `dac_i` and `dac_q` are zero. A gain of zero gives zero output samples.
- R8: A word with length 0 is accepted but produces no samples, and `s_tready` stays high.
- R9: After reset, `s_tready`=1, `dac_valid`=0 and both outputs are zero.
- R10: `s_tready` returns high after edge EL, so the next pulse can be accepted on edge EL+1. Each pulse uses its own frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Control word valid |
| s_tready | output | 1 | Ready for a control word (IDLE) |
| s_tdata | input | 112 | Control word |
| env_we | input | 1 | Envelope write enable |
| env_waddr | input | ENV_AW | Envelope write address |
| env_wi | input | 16 | Envelope I sample, signed |
| env_wq | input | 16 | Envelope Q sample, signed |
| dac_valid | output | 1 | Output sample valid |
| dac_i | output | 16 | Output I sample, signed |
| dac_q | output | 16 | Output Q sample, signed |

## Verification
The assertions check the following on every cycle:
- the handshake drops `s_tready` for a non-zero length and keeps it high for a zero length;
- the outputs are zero whenever `dac_valid` is low;
- a zero gain yields zero samples;
- `dac_valid` cannot fall in the middle of a pulse.

Only the bench's scenarios can show the numeric behaviour: the phase progression across samples, table lookup, envelope address wrap, the mixing arithmetic, saturation, and a frequency change between back-to-back pulses. The bench compares every emitted sample against values it computes itself.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;

    localparam int SAMP_W = 16;
    localparam int CW_W   = 112;
    localparam int ACC_W  = 48;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } pg_state_t;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] base;
        logic [15:0] gain;
        logic [31:0] phase;
        logic [31:0] freq;
    } pg_word_t;

    function automatic logic signed [SAMP_W-1:0] sat16(input logic signed [ACC_W-1:0] v);
        if (v > ACC_W'(32767))
            return 16'sd32767;
        else if (v < -ACC_W'(32768))
            return -16'sd32768;
        else
            return v[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/pg_sine_lut.sv
module pg_sine_lut #(
    parameter int LUT_BITS = 8
) (
    input  logic [LUT_BITS-1:0]        idx,
    output logic signed [15:0]         sin_o,
    output logic signed [15:0]         cos_o
);
    localparam int N   = 1 << LUT_BITS;
    localparam int QTR = N / 4;

    function automatic int tab_val(input int k);
        real a;
        a = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k) / real'(N));
        return (a >= 0.0) ? $rtoi(a + 0.5) : $rtoi(a - 0.5);
    endfunction

    logic signed [15:0] tab [N];

    for (genvar k = 0; k < N; k++) begin : g_tab
        localparam int V = tab_val(k);
        assign tab[k] = 16'(V);
    end

    logic [LUT_BITS-1:0] cidx;
    assign cidx  = idx + LUT_BITS'(QTR);
    assign sin_o = tab[idx];
    assign cos_o = tab[cidx];
endmodule

// File: rtl/pg_env_mem.sv
module pg_env_mem #(
    parameter int ENV_AW = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ENV_AW-1:0]       waddr,
    input  logic signed [15:0]      wi,
    input  logic signed [15:0]      wq,
    input  logic [ENV_AW-1:0]       raddr,
    output logic signed [15:0]      ri,
    output logic signed [15:0]      rq
);
    localparam int DEPTH = 1 << ENV_AW;

    logic signed [15:0] mem_i [DEPTH];
    logic signed [15:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_i[waddr] <= wi;
            mem_q[waddr] <= wq;
        end
    end

    assign ri = mem_i[raddr];
    assign rq = mem_q[raddr];
endmodule

// File: rtl/pg_mixer.sv
module pg_mixer
    import pulse_gen_pkg::*;
(
    input  logic signed [15:0] env_i,
    input  logic signed [15:0] env_q,
    input  logic signed [15:0] car_cos,
    input  logic signed [15:0] car_sin,
    input  logic signed [15:0] gain,
    output logic signed [15:0] y_i,
    output logic signed [15:0] y_q
);
    logic signed [ACC_W-1:0] ei, eq, c, s, g;
    logic signed [ACC_W-1:0] mix_i, mix_q, sc_i, sc_q;

    always_comb begin
        ei    = ACC_W'(env_i);
        eq    = ACC_W'(env_q);
        c     = ACC_W'(car_cos);
        s     = ACC_W'(car_sin);
        g     = ACC_W'(gain);
        mix_i = (ei * c - eq * s) >>> 15;
        mix_q = (ei * s + eq * c) >>> 15;
        sc_i  = (mix_i * g) >>> 15;
        sc_q  = (mix_q * g) >>> 15;
        y_i   = sat16(sc_i);
        y_q   = sat16(sc_q);
    end
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
    import pulse_gen_pkg::*;
#(
    parameter int ENV_AW   = 8,
    parameter int LUT_BITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_tvalid,
    output logic                    s_tready,
    input  logic [CW_W-1:0]         s_tdata,
    input  logic                    env_we,
    input  logic [ENV_AW-1:0]       env_waddr,
    input  logic signed [15:0]      env_wi,
    input  logic signed [15:0]      env_wq,
    output logic                    dac_valid,
    output logic signed [15:0]      dac_i,
    output logic signed [15:0]      dac_q
);
    pg_state_t          state, state_nx;
    pg_word_t           word;
    logic               take;
    logic [31:0]        acc_q, freq_q;
    logic [15:0]        gain_q;
    logic [15:0]        cnt_q;
    logic [ENV_AW-1:0]  raddr_q;
    logic signed [15:0] env_i, env_q, c_s, c_c, y_i, y_q;

    assign word     = pg_word_t'(s_tdata);
    assign s_tready = (state == ST_IDLE);
    assign take     = s_tvalid && s_tready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take && word.len != 16'd0) state_nx = ST_PLAY;   // accept
            ST_PLAY: if (cnt_q == 16'd1)            state_nx = ST_IDLE;   // finish
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            freq_q    <= '0;
            gain_q    <= '0;
            cnt_q     <= '0;
            raddr_q   <= '0;
            dac_valid <= 1'b0;
            dac_i     <= '0;
            dac_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    dac_valid <= 1'b0;
                    dac_i     <= '0;
                    dac_q     <= '0;
                    if (take) begin
                        acc_q   <= word.phase;
                        freq_q  <= word.freq;
                        gain_q  <= word.gain;
                        cnt_q   <= word.len;
                        raddr_q <= word.base[ENV_AW-1:0];
                    end
                end
                ST_PLAY: begin
                    dac_valid <= 1'b1;
                    dac_i     <= y_i;
                    dac_q     <= y_q;
                    acc_q     <= acc_q + freq_q;
                    raddr_q   <= raddr_q + 1'b1;
                    cnt_q     <= cnt_q - 16'd1;
                end
                default: ;
            endcase
        end
    end

    pg_env_mem #(.ENV_AW(ENV_AW)) u_mem (
        .clk(clk), .we(env_we), .waddr(env_waddr), .wi(env_wi), .wq(env_wq),
        .raddr(raddr_q), .ri(env_i), .rq(env_q)
    );

    pg_sine_lut #(.LUT_BITS(LUT_BITS)) u_lut (
        .idx(acc_q[31 -: LUT_BITS]), .sin_o(c_s), .cos_o(c_c)
    );

    pg_mixer u_mix (
        .env_i(env_i), .env_q(env_q), .car_cos(c_c), .car_sin(c_s),
        .gain(signed'(gain_q)), .y_i(y_i), .y_q(y_q)
    );

    // Assertions
    assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && s_tdata[111:96] != 16'd0) |=> !s_tready);

    assert_zero_len_keeps_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && s_tdata[111:96] == 16'd0) |=> (s_tready && !dac_valid));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> (dac_i == 16'sd0 && dac_q == 16'sd0));

    assert_zero_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && gain_q == 16'd0) |=> (dac_i == 16'sd0 && dac_q == 16'sd0));

    assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && !s_tready) |=> dac_valid);
endmodule

// File: tb/pulse_gen_test.sv
module pulse_gen_test;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_tvalid = 1'b0;
    logic s_tready;
    logic [111:0] s_tdata = '0;
    logic env_we = 1'b0;
    logic [AW-1:0] env_waddr = '0;
    logic signed [15:0] env_wi = '0, env_wq = '0;
    logic dac_valid;
    logic signed [15:0] dac_i, dac_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_i [DEPTH];
    int m_q [DEPTH];

    always #2 clk = ~clk;

    pulse_gen #(.ENV_AW(AW), .LUT_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tdata(s_tdata), .env_we(env_we), .env_waddr(env_waddr),
        .env_wi(env_wi), .env_wq(env_wq), .dac_valid(dac_valid),
        .dac_i(dac_i), .dac_q(dac_q)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint tsin(input int k);
        real a;
        a = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k % 256) / 256.0);
        return (a >= 0.0) ? longint'($rtoi(a + 0.5)) : longint'($rtoi(a - 0.5));
    endfunction

    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic wr_env(input int a, input int vi, input int vq);
        @(negedge clk);
        env_we = 1'b1; env_waddr = AW'(a); env_wi = 16'(vi); env_wq = 16'(vq);
        m_i[a] = vi; m_q[a] = vq;
        @(negedge clk);
        env_we = 1'b0;
    endtask

    // Play one pulse and compare every sample; busy=1 offers a junk word during PLAY
    task automatic play(input logic [31:0] fr, input logic [31:0] ph, input int g,
                        input int base, input int len, input bit busy);
        logic [31:0] p;
        longint ei, eq, s, c, mi, mq;
        int k, a;
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata = {16'(len), 16'(base), 16'(g), ph, fr};
        @(posedge clk);
        @(negedge clk);
        if (busy) s_tdata = {16'd3, 16'd0, 16'd100, 32'd0, 32'h1234_5678};
        else s_tvalid = 1'b0;
        if (len == 0) begin
            s_tvalid = 1'b0;
            chk("R8 ready after zero length", s_tready, 1);
            @(posedge clk); @(negedge clk);
            chk("R8 no sample", dac_valid, 0);
            return;
        end
        chk("R1 ready low while playing", s_tready, 0);
        for (int n = 0; n < len; n++) begin
            @(posedge clk); @(negedge clk);
            p = ph + fr * 32'(n);
            k = int'(p[31:24]);
            s = tsin(k); c = tsin(k + 64);
            a = (base + n) % DEPTH;
            ei = m_i[a]; eq = m_q[a];
            mi = (ei * c - eq * s) >>> 15;
            mq = (ei * s + eq * c) >>> 15;
            chk("R2 valid", dac_valid, 1);
            chk("R3/R4/R5/R6 sample I", dac_i, sat((mi * g) >>> 15));
            chk("R3/R4/R5/R6 sample Q", dac_q, sat((mq * g) >>> 15));
            if (n == len - 1) begin
                s_tvalid = 1'b0;
                chk("R10 ready back on last sample", s_tready, 1);
            end
        end
        @(posedge clk); @(negedge clk);
        chk("R2 valid ends", dac_valid, 0);
        chk("R7 idle I zero", dac_i, 0);
        chk("R7 idle Q zero", dac_q, 0);
    endtask

    initial begin
        int r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready", s_tready, 1);
        chk("R9 valid", dac_valid, 0);
        chk("R9 I", dac_i, 0);
        chk("R9 Q", dac_q, 0);

        for (int a = 0; a < DEPTH; a++)
            wr_env(a, int'($signed(16'($urandom))), int'($signed(16'($urandom))));

        // Directed: flat envelope, zero frequency
        wr_env(10, 16000, 0);
        play(32'd0, 32'd0, 32767, 10, 1, 0);
        // R7 zero gain
        play(32'h0100_0000, 32'd0, 0, 20, 5, 0);
        // R6 saturation
        wr_env(40, 32767, -32768);
        wr_env(41, -32768, 32767);
        play(32'd0, 32'h2000_0000, 32767, 40, 2, 0);
        play(32'd0, 32'h2000_0000, -32768, 40, 2, 0);
        // R4 address wrap
        play(32'h0300_0000, 32'h8000_0000, 20000, 250, 12, 0);
        // R8 zero length
        play(32'h0100_0000, 32'd0, 1000, 0, 0, 0);
        // R1 word during PLAY ignored
        play(32'h0080_0000, 32'h4000_0000, 12345, 100, 8, 1);
        // R10 frequency hopping, back-to-back random pulses
        for (int t = 0; t < 12; t++)
            play($urandom, $urandom, int'($signed(16'($urandom))),
                 int'($urandom_range(0, DEPTH - 1)), int'($urandom_range(1, 20)), t[0]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule